// File: doc/BRIEF.md
# ALU Condition Code Register

This block holds the status word of a small 8-bit accumulator CPU. Each cycle it can take the ALU result and the side outputs of the adder and shifter: the carry out of bit 3, the carry out of bit 7, the two's-complement overflow indication and the bit shifted out. Separate update strobes, one per arithmetic flag, let the decoder change only the flags that the current instruction affects. The flags are half-carry (H), negative (N), zero (Z), overflow (V) and carry (C).

The same word also holds an interrupt enable bit and an interrupt threshold field. Each incoming request carries a level, where 0 is the most urgent. The block compares that level with the threshold and raises an accept line. Software can load the whole word in one cycle and can read it back at any time. The read value comes straight from the state flops.

Top module: `ccr_unit`

## Requirements
- R1: A synchronous active-high reset clears H, N, Z, V, C and the enable bit and sets the threshold field to all ones. With the defaults the read value is 0x60. The layout is C bit 0, V bit 1, Z bit 2, N bit 3, H bit 4, threshold bits 6:5 and enable bit 7.
- R2: When `upd_h_i` is high, H takes `c3_i` at the next edge. A carry or borrow across bit 3 therefore sets H, and its absence clears H.
- R3: When `upd_n_i` is high, N takes the most significant bit of `res_i`. When `upd_z_i` is high, Z becomes 1 only if every bit of `res_i` is 0.
- R4: When `upd_v_i` is high, V takes `ovf_i`.
- R5: When `upd_c_i` is high, C takes `c7_i`. If `shift_i` is also high, C takes `shout_i` instead.
- R6: A flag whose strobe is low keeps its value, whatever the data inputs do. The enable bit and the threshold change only through a register write.
- R7: When `wr_en_i` is high, the whole word is loaded from `wr_data_i` at the next edge. This write wins over any flag strobe in the same cycle.
- R8: `irq_take_o` is combinational. It is 1 only when the enable bit is 1, `irq_valid_i` is 1 and `irq_level_i` is numerically smaller than the threshold. A threshold of 0 therefore blocks every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_i | input | DATA_W | ALU result |
| c3_i | input | 1 | Carry or borrow out of bit 3 |
| c7_i | input | 1 | Carry or borrow out of the top bit |
| ovf_i | input | 1 | Two's-complement overflow |
| shout_i | input | 1 | Bit shifted out by the shifter |
| shift_i | input | 1 | Current operation is a shift; C takes `shout_i` |
| upd_h_i | input | 1 | Update strobe for H |
| upd_n_i | input | 1 | Update strobe for N |
| upd_z_i | input | 1 | Update strobe for Z |
| upd_v_i | input | 1 | Update strobe for V |
| upd_c_i | input | 1 | Update strobe for C |
| wr_en_i | input | 1 | Load the whole word |
| wr_data_i | input | LVL_W+6 | Word to load |
| rd_data_o | output | LVL_W+6 | Current register contents |
| irq_valid_i | input | 1 | Interrupt request present |
| irq_level_i | input | LVL_W | Level of the request, 0 most urgent |
| irq_take_o | output | 1 | Request accepted |

## Verification
The bench builds the block with the default DATA_W=8 and LVL_W=2. These values give an 8-bit word and four levels.

Four levels make the threshold comparison small enough to sweep in full. Every request level is checked against every threshold, with the enable bit both set and clear. This covers the case where a threshold of 0 blocks all requests.

The 8-bit result width brings the Z and N boundaries within reach: a result of 0x00, a result of 0x80 and results that differ in a single bit.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned POS_C  = 0;
  localparam int unsigned POS_V  = 1;
  localparam int unsigned POS_Z  = 2;
  localparam int unsigned POS_N  = 3;
  localparam int unsigned POS_H  = 4;
  localparam int unsigned POS_IL = 5;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/ccr_flag_next.sv
module ccr_flag_next
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  arith_flags_t      cur_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              c3_i,
  input  logic              c7_i,
  input  logic              ovf_i,
  input  logic              shout_i,
  input  logic              shift_i,
  input  logic              upd_h_i,
  input  logic              upd_n_i,
  input  logic              upd_z_i,
  input  logic              upd_v_i,
  input  logic              upd_c_i,
  output arith_flags_t      nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (upd_h_i) nxt_o.h = c3_i;
    if (upd_n_i) nxt_o.n = res_i[DATA_W-1];
    if (upd_z_i) nxt_o.z = (res_i == '0);
    if (upd_v_i) nxt_o.v = ovf_i;
    if (upd_c_i) nxt_o.c = shift_i ? shout_i : c7_i;
  end
endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate #(
  parameter int unsigned LVL_W = 2
) (
  input  logic             ie_i,
  input  logic [LVL_W-1:0] thr_i,
  input  logic             req_valid_i,
  input  logic [LVL_W-1:0] req_level_i,
  output logic             take_o
);
  logic more_urgent;

  assign more_urgent = (req_level_i < thr_i);
  assign take_o      = ie_i & req_valid_i & more_urgent;
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LVL_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   res_i,
  input  logic                c3_i,
  input  logic                c7_i,
  input  logic                ovf_i,
  input  logic                shout_i,
  input  logic                shift_i,
  input  logic                upd_h_i,
  input  logic                upd_n_i,
  input  logic                upd_z_i,
  input  logic                upd_v_i,
  input  logic                upd_c_i,
  input  logic                wr_en_i,
  input  logic [LVL_W+5:0]    wr_data_i,
  output logic [LVL_W+5:0]    rd_data_o,
  input  logic                irq_valid_i,
  input  logic [LVL_W-1:0]    irq_level_i,
  output logic                irq_take_o
);
  localparam int unsigned REG_W  = LVL_W + 6;
  localparam int unsigned POS_IE = POS_IL + LVL_W;
  localparam logic [REG_W-1:0] RST_VAL = {1'b0, {LVL_W{1'b1}}, 5'b0};

  arith_flags_t     fl_q, fl_nxt;
  logic             ie_q;
  logic [LVL_W-1:0] thr_q;

  ccr_flag_next #(.DATA_W(DATA_W)) u_next (
    .cur_i   (fl_q),
    .res_i   (res_i),
    .c3_i    (c3_i),
    .c7_i    (c7_i),
    .ovf_i   (ovf_i),
    .shout_i (shout_i),
    .shift_i (shift_i),
    .upd_h_i (upd_h_i),
    .upd_n_i (upd_n_i),
    .upd_z_i (upd_z_i),
    .upd_v_i (upd_v_i),
    .upd_c_i (upd_c_i),
    .nxt_o   (fl_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_q  <= '0;
      ie_q  <= 1'b0;
      thr_q <= '1;
    end else if (wr_en_i) begin
      fl_q.c <= wr_data_i[POS_C];
      fl_q.v <= wr_data_i[POS_V];
      fl_q.z <= wr_data_i[POS_Z];
      fl_q.n <= wr_data_i[POS_N];
      fl_q.h <= wr_data_i[POS_H];
      thr_q  <= wr_data_i[POS_IL +: LVL_W];
      ie_q   <= wr_data_i[POS_IE];
    end else begin
      fl_q <= fl_nxt;
    end
  end

  always_comb begin
    rd_data_o                  = '0;
    rd_data_o[POS_C]           = fl_q.c;
    rd_data_o[POS_V]           = fl_q.v;
    rd_data_o[POS_Z]           = fl_q.z;
    rd_data_o[POS_N]           = fl_q.n;
    rd_data_o[POS_H]           = fl_q.h;
    rd_data_o[POS_IL +: LVL_W] = thr_q;
    rd_data_o[POS_IE]          = ie_q;
  end

  ccr_irq_gate #(.LVL_W(LVL_W)) u_gate (
    .ie_i        (ie_q),
    .thr_i       (thr_q),
    .req_valid_i (irq_valid_i),
    .req_level_i (irq_level_i),
    .take_o      (irq_take_o)
  );

  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> rd_data_o == RST_VAL);

  a_r2_half_carry: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && upd_h_i) |=> rd_data_o[POS_H] == $past(c3_i));

  a_r3_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && upd_z_i) |=> rd_data_o[POS_Z] == ($past(res_i) == '0));

  a_r3_neg_flag: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && upd_n_i) |=> rd_data_o[POS_N] == $past(res_i[DATA_W-1]));

  a_r4_overflow: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && upd_v_i) |=> rd_data_o[POS_V] == $past(ovf_i));

  a_r5_shift_carry: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && upd_c_i && shift_i) |=> rd_data_o[POS_C] == $past(shout_i));

  a_r6_hold_carry: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_i && !upd_c_i) |=> $stable(rd_data_o[POS_C]));

  a_r6_hold_ctrl: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(rd_data_o[REG_W-1:POS_IL]));

  a_r7_write_load: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> rd_data_o == $past(wr_data_i));

  a_r8_take_gated: assert property (@(posedge clk) disable iff (rst)
    irq_take_o |-> (rd_data_o[POS_IE] && irq_valid_i
                    && irq_level_i < rd_data_o[POS_IL +: LVL_W]));
endmodule

// File: tb/ccr_unit_bench.sv
`timescale 1ns/1ps
module ccr_unit_bench;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LVL_W  = 2;
  localparam int unsigned REG_W  = LVL_W + 6;

  typedef struct {
    logic [REG_W-1:0] exp;
    string            tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] res_i = '0;
  logic c3_i = 0, c7_i = 0, ovf_i = 0, shout_i = 0, shift_i = 0;
  logic upd_h_i = 0, upd_n_i = 0, upd_z_i = 0, upd_v_i = 0, upd_c_i = 0;
  logic wr_en_i = 0;
  logic [REG_W-1:0] wr_data_i = '0;
  logic [REG_W-1:0] rd_data_o;
  logic irq_valid_i = 0;
  logic [LVL_W-1:0] irq_level_i = '0;
  logic irq_take_o;

  int total = 0;
  int bad = 0;
  logic [REG_W-1:0] mdl;
  item_t sq[$];

  always #2.5 clk = ~clk;

  ccr_unit #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_ccr_unit (
    .clk(clk), .rst(rst), .res_i(res_i), .c3_i(c3_i), .c7_i(c7_i),
    .ovf_i(ovf_i), .shout_i(shout_i), .shift_i(shift_i),
    .upd_h_i(upd_h_i), .upd_n_i(upd_n_i), .upd_z_i(upd_z_i),
    .upd_v_i(upd_v_i), .upd_c_i(upd_c_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .irq_valid_i(irq_valid_i), .irq_level_i(irq_level_i),
    .irq_take_o(irq_take_o)
  );

  // monitor: pops one expected word per cycle and compares
  always @(negedge clk) begin
    while (sq.size() > 0) begin
      item_t it;
      it = sq.pop_front();
      total++;
      if (rd_data_o !== it.exp) begin
        bad++;
        $display("FAIL %s: reg actual=%h expected=%h", it.tag, rd_data_o, it.exp);
      end
    end
  end

  // upd = {h,n,z,v,c}
  task automatic step(input string tag, input logic wr, input logic [REG_W-1:0] wd,
                      input logic [DATA_W-1:0] res, input logic c3, input logic c7,
                      input logic ovf, input logic so, input logic sh, input logic [4:0] upd,
                      input logic rv, input logic [LVL_W-1:0] lvl);
    logic exp_take;
    item_t it;
    @(negedge clk);
    wr_en_i = wr; wr_data_i = wd; res_i = res; c3_i = c3; c7_i = c7;
    ovf_i = ovf; shout_i = so; shift_i = sh;
    {upd_h_i, upd_n_i, upd_z_i, upd_v_i, upd_c_i} = upd;
    irq_valid_i = rv; irq_level_i = lvl;
    #1;
    exp_take = mdl[REG_W-1] && rv && (lvl < mdl[5 +: LVL_W]);
    total++;
    if (irq_take_o !== exp_take) begin
      bad++;
      $display("FAIL R8 (%s): take actual=%b expected=%b", tag, irq_take_o, exp_take);
    end
    if (wr) mdl = wd;
    else begin
      if (upd[4]) mdl[4] = c3;
      if (upd[3]) mdl[3] = res[DATA_W-1];
      if (upd[2]) mdl[2] = (res == 0);
      if (upd[1]) mdl[1] = ovf;
      if (upd[0]) mdl[0] = sh ? so : c7;
    end
    @(posedge clk); #1;
    it.exp = mdl; it.tag = tag;
    sq.push_back(it);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    item_t it;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    mdl = 8'h60;
    it.exp = 8'h60; it.tag = "R1 reset";
    sq.push_back(it);
    // R8: enable clear after reset, request refused
    step("R8 ie0", 0, '0, 8'h11, 0, 0, 0, 0, 0, 5'b00000, 1, 2'd0);
    // R2 R3 R5: zero result with carries
    step("R2 R3 R5 zero", 0, '0, 8'h00, 1, 1, 0, 0, 0, 5'b11111, 0, 2'd0);
    // R3 R4: 0x80 with overflow
    step("R3 R4 neg", 0, '0, 8'h80, 0, 0, 1, 0, 0, 5'b11111, 0, 2'd0);
    // R5: shift takes shout, not c7
    step("R5 shift", 0, '0, 8'h01, 0, 0, 0, 1, 1, 5'b00001, 0, 2'd0);
    step("R5 shift0", 0, '0, 8'h01, 0, 1, 0, 0, 1, 5'b00001, 0, 2'd0);
    // R6: no strobes, inputs all toggled
    step("R6 hold", 0, '0, 8'h00, 1, 1, 0, 1, 0, 5'b00000, 0, 2'd0);
    // R6: only Z strobe
    step("R6 only z", 0, '0, 8'h00, 1, 1, 0, 1, 0, 5'b00100, 0, 2'd0);
    step("R3 z single bit", 0, '0, 8'h04, 1, 0, 1, 0, 0, 5'b00110, 0, 2'd0);
    // R7: write wins over strobes
    step("R7 write prio", 1, 8'h9F, 8'h00, 0, 0, 0, 0, 0, 5'b11111, 0, 2'd0);
    step("R7 write zero", 1, 8'h00, 8'hFF, 1, 1, 1, 1, 0, 5'b11111, 1, 2'd0);
    // R8: sweep every threshold and level, enable on and off
    for (int ie = 0; ie < 2; ie++) begin
      for (int th = 0; th < 4; th++) begin
        step("R7 load thr", 1, {ie[0], th[1:0], 5'b10101}, 8'h00, 0, 0, 0, 0, 0, 5'b00000, 0, 2'd0);
        for (int lv = 0; lv < 4; lv++) begin
          step("R8 sweep", 0, '0, 8'h00, 0, 0, 0, 0, 0, 5'b00000, 1, lv[1:0]);
          step("R8 novalid", 0, '0, 8'h00, 0, 0, 0, 0, 0, 5'b00000, 0, lv[1:0]);
        end
      end
    end
    // R2: H cleared when no carry from bit 3
    step("R2 h set", 0, '0, 8'h10, 1, 0, 0, 0, 0, 5'b10000, 0, 2'd0);
    step("R2 h clr", 0, '0, 8'h10, 0, 0, 0, 0, 0, 5'b10000, 0, 2'd0);
    // R1: reset again from non-reset state
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    mdl = 8'h60;
    it.exp = 8'h60; it.tag = "R1 re-reset";
    sq.push_back(it);
    @(negedge clk); @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule